// File: doc/BRIEF.md
# Data-Processing Execution Unit with Condition Flags

This block executes the sixteen data-processing operations of a 32-bit register-to-register instruction set. Each cycle it receives an opcode, two operands that have already been read and shifted, a set-flags bit, and the carry produced by the operand shifter. In the same cycle it returns the result, a write enable for the destination register, and the condition flags that the instruction will leave behind. The four condition flags (negative, zero, carry, overflow) are held in a register inside the block. That register takes its new value on the clock edge that ends a valid cycle with the set-flags bit high.

The opcodes fall into three classes. The logical class has the bitwise operations and the moves. The add class has plain add, add with carry and compare-negative. The subtract class has subtract, reverse subtract, the two carry-chained subtracts and compare. The class decides where carry and overflow come from. Four test and compare opcodes produce flags only and never request a register write. The carry-chained operations read the carry flag from the internal register, so a sequence of them behaves as a multi-word add or subtract.

Top module: `dp_exec_unit`

## Requirements
- R1: Logical opcodes give these results: 0000 = A AND B, 0001 = A XOR B, 1100 = A OR B, 1101 = B, 1110 = A AND NOT B, 1111 = NOT B.
- R2: Arithmetic opcodes without carry give these results modulo 2^W: 0100 = A+B, 0010 = A−B, 0011 = B−A.
- R3: Carry-chained opcodes use the registered carry flag C: 0101 = A+B+C, 0110 = A−B−(1−C), 0111 = B−A−(1−C).
- R4: Opcodes 1000, 1001, 1010 and 1011 compute A AND B, A XOR B, A−B and A+B on result_o, and keep wr_en_o low. Every other opcode drives wr_en_o equal to valid_i.
- R5: flags_o and flags_nxt_o carry {N,Z,C,V} in bits 3 down to 0. When valid_i and set_flags_i are both high, the new N is bit W−1 of the result and the new Z is 1 exactly when the result is zero. flags_nxt_o shows the new value in the same cycle, and flags_o shows it after the next rising clock edge.
- R6: For the add class (0100, 0101, 1011) with flags set, C becomes the carry out of the top bit. V becomes 1 when A and B have the same sign and the result's sign differs from theirs.
- R7: For the subtract class (0010, 0011, 0110, 0111, 1010) with flags set, C becomes 1 when the unsigned minuend is at least the subtrahend plus the borrow. V becomes 1 when minuend and subtrahend differ in sign and the result's sign differs from the minuend's.
- R8: For logical and test opcodes with flags set, C takes shift_carry_i and V keeps its previous value.
- R9: When valid_i is low or set_flags_i is low, all four flags keep their value.
- R10: While rst_n is low, flags_o is zero and wr_en_o is low when valid_i is low. The flag register ignores updates until two rising edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Update the condition flags |
| op_a_i | input | DATA_W | First operand |
| op_b_i | input | DATA_W | Second operand, already shifted |
| shift_carry_i | input | 1 | Carry out of the operand shifter |
| result_o | output | DATA_W | Operation result |
| wr_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Registered {N,Z,C,V} |
| flags_nxt_o | output | 4 | Flags this instruction will leave |

## Verification
A wrong value in the held carry bit reaches the ports in two ways. It appears on flags_o one cycle after the update, and it shifts the result of the next carry-chained add or subtract by one in that same cycle. A wrong overflow or carry source shows up on flags_nxt_o immediately, before the register takes it. The bench seeds the carry with a flag-setting move before every vector, so each operation runs with both carry values. This catches stale-carry and wrong-class errors within one instruction.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2
  } op_cls_e;

  typedef enum logic [2:0] {
    LF_AND   = 3'd0,
    LF_XOR   = 3'd1,
    LF_OR    = 3'd2,
    LF_PASSB = 3'd3,
    LF_ANDN  = 3'd4,
    LF_NOTB  = 3'd5
  } logic_fn_e;

  typedef struct packed {
    op_cls_e   cls;
    logic      swap;
    logic      carry_chain;
    logic      writes_rd;
    logic_fn_e lfn;
  } op_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/dpx_decode.sv
module dpx_decode
  import dpx_pkg::*;
(
  input  logic [3:0] opcode_i,
  output op_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o.cls         = CLS_LOGIC;
    ctrl_o.swap        = 1'b0;
    ctrl_o.carry_chain = 1'b0;
    ctrl_o.writes_rd   = 1'b1;
    ctrl_o.lfn         = LF_AND;
    case (dp_op_e'(opcode_i))
      OP_AND: ctrl_o.lfn = LF_AND;
      OP_EOR: ctrl_o.lfn = LF_XOR;
      OP_SUB: ctrl_o.cls = CLS_SUB;
      OP_RSB: begin ctrl_o.cls = CLS_SUB; ctrl_o.swap = 1'b1; end
      OP_ADD: ctrl_o.cls = CLS_ADD;
      OP_ADC: begin ctrl_o.cls = CLS_ADD; ctrl_o.carry_chain = 1'b1; end
      OP_SBC: begin ctrl_o.cls = CLS_SUB; ctrl_o.carry_chain = 1'b1; end
      OP_RSC: begin
        ctrl_o.cls = CLS_SUB; ctrl_o.swap = 1'b1; ctrl_o.carry_chain = 1'b1;
      end
      OP_TST: begin ctrl_o.lfn = LF_AND; ctrl_o.writes_rd = 1'b0; end
      OP_TEQ: begin ctrl_o.lfn = LF_XOR; ctrl_o.writes_rd = 1'b0; end
      OP_CMP: begin ctrl_o.cls = CLS_SUB; ctrl_o.writes_rd = 1'b0; end
      OP_CMN: begin ctrl_o.cls = CLS_ADD; ctrl_o.writes_rd = 1'b0; end
      OP_ORR: ctrl_o.lfn = LF_OR;
      OP_MOV: ctrl_o.lfn = LF_PASSB;
      OP_BIC: ctrl_o.lfn = LF_ANDN;
      OP_MVN: ctrl_o.lfn = LF_NOTB;
      default: ctrl_o.lfn = LF_AND;
    endcase
  end

endmodule

// File: rtl/dpx_addsub.sv
module dpx_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] y_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    wide   = {1'b0, x_i} + {1'b0, y_eff} + {{DATA_W{1'b0}}, cin_i};
    sum_o  = wide[MSB:0];
    cout_o = wide[DATA_W];
    ovf_o  = (x_i[MSB] == y_eff[MSB]) && (wide[MSB] != x_i[MSB]);
  end

endmodule

// File: rtl/dpx_logic_unit.sv
module dpx_logic_unit
  import dpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (fn_i)
      LF_AND:   res_o = a_i & b_i;
      LF_XOR:   res_o = a_i ^ b_i;
      LF_OR:    res_o = a_i | b_i;
      LF_PASSB: res_o = b_i;
      LF_ANDN:  res_o = a_i & ~b_i;
      LF_NOTB:  res_o = ~b_i;
      default:  res_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/dpx_flag_reg.sv
module dpx_flag_reg
  import dpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic              is_logic_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  input  logic              shc_i,
  output nzcv_t             flags_q_o,
  output nzcv_t             flags_nxt_o
);

  localparam int MSB = DATA_W - 1;

  logic [1:0] rs_q;
  logic       rst_ok;
  logic       upd_en;
  nzcv_t      flags_q;
  nzcv_t      flags_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  always_comb begin
    flags_nxt = flags_q;
    if (upd_i) begin
      flags_nxt.n = res_i[MSB];
      flags_nxt.z = (res_i == '0);
      if (is_logic_i) begin
        flags_nxt.c = shc_i;
      end else begin
        flags_nxt.c = cout_i;
        flags_nxt.v = ovf_i;
      end
    end
  end

  assign upd_en = upd_i & rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_nxt;
  end

  assign flags_q_o   = flags_q;
  assign flags_nxt_o = flags_nxt;

  // R5
  z_from_result_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_i |=> flags_q.z == ($past(res_i) == '0));
  // R5
  n_from_result_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_i |=> flags_q.n == $past(res_i[MSB]));
  // R8
  logic_v_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_i && is_logic_i |=> flags_q.v == $past(flags_q.v));
  // R8
  logic_c_shift_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_i && is_logic_i |=> flags_q.c == $past(shc_i));
  // R9
  no_update_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !upd_i |=> $stable(flags_q));

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        opcode_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              shift_carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o,
  output logic [3:0]        flags_nxt_o
);

  op_ctrl_t          ctrl;
  nzcv_t             flags_q;
  nzcv_t             flags_nxt;
  logic [DATA_W-1:0] x_opnd;
  logic [DATA_W-1:0] y_opnd;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic              is_sub;
  logic              is_logic;
  logic              adder_cin;
  logic              adder_cout;
  logic              adder_ovf;

  dpx_decode u_decode (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  always_comb begin
    is_sub    = (ctrl.cls == CLS_SUB);
    is_logic  = (ctrl.cls == CLS_LOGIC);
    x_opnd    = ctrl.swap ? op_b_i : op_a_i;
    y_opnd    = ctrl.swap ? op_a_i : op_b_i;
    if (ctrl.carry_chain) adder_cin = flags_q.c;
    else                  adder_cin = is_sub;
  end

  dpx_addsub #(.DATA_W(DATA_W)) u_addsub (
    .x_i    (x_opnd),
    .y_i    (y_opnd),
    .sub_i  (is_sub),
    .cin_i  (adder_cin),
    .sum_o  (arith_res),
    .cout_o (adder_cout),
    .ovf_o  (adder_ovf)
  );

  dpx_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .fn_i  (ctrl.lfn),
    .res_o (logic_res)
  );

  assign result_o = is_logic ? logic_res : arith_res;
  assign wr_en_o  = valid_i & ctrl.writes_rd;

  dpx_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (valid_i & set_flags_i),
    .is_logic_i  (is_logic),
    .res_i       (result_o),
    .cout_i      (adder_cout),
    .ovf_i       (adder_ovf),
    .shc_i       (shift_carry_i),
    .flags_q_o   (flags_q),
    .flags_nxt_o (flags_nxt)
  );

  assign flags_o     = flags_q;
  assign flags_nxt_o = flags_nxt;

  // R4
  test_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (opcode_i[3:2] == 2'b10) |-> !wr_en_o);
  // R4
  idle_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !wr_en_o);

endmodule

// File: tb/dp_exec_unit_bench.sv
module dp_exec_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int MSB = DW - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid_i;
  logic [3:0]    opcode_i;
  logic          set_flags_i;
  logic [DW-1:0] op_a_i;
  logic [DW-1:0] op_b_i;
  logic          shift_carry_i;
  logic [DW-1:0] result_o;
  logic          wr_en_o;
  logic [3:0]    flags_o;
  logic [3:0]    flags_nxt_o;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [3:0] model_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_exec_unit #(.DATA_W(DW)) u_dp_exec_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_i       (valid_i),
    .opcode_i      (opcode_i),
    .set_flags_i   (set_flags_i),
    .op_a_i        (op_a_i),
    .op_b_i        (op_b_i),
    .shift_carry_i (shift_carry_i),
    .result_o      (result_o),
    .wr_en_o       (wr_en_o),
    .flags_o       (flags_o),
    .flags_nxt_o   (flags_nxt_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s op=%0h a=%0h b=%0h: actual=%0h expected=%0h",
               tag, what, opcode_i, op_a_i, op_b_i, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input int i);
    logic [DW-1:0] v;
    case (i)
      0: v = '0;
      1: v = 1;
      2: v = 2;
      3: v = '1;
      4: v = '1 - 1;
      5: v = 1 << MSB;
      6: v = (1 << MSB) - 1;
      7: v = (1 << MSB) + 1;
      8: v = {(DW/2){2'b01}};
      9: v = {(DW/2){2'b10}};
      default: v = DW'(i * 59 + 7);
    endcase
    return v;
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    if (op[3:2] == 2'b10) return "R4";
    if (op == 4'h5 || op == 4'h6 || op == 4'h7) return "R3";
    if (op == 4'h2 || op == 4'h3 || op == 4'h4) return "R2";
    return "R1";
  endfunction

  task automatic model(input logic [3:0] op, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic s, input logic shc,
                       input logic [3:0] fin, output logic [DW-1:0] r,
                       output logic we, output logic [3:0] fo);
    logic [DW:0]   w;
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic          bor;
    logic          cy;
    logic          ov;
    int            kind;
    kind = 0; x = a; y = b; bor = 1'b0; cy = 1'b0; ov = 1'b0; r = '0;
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h4, 4'hB: kind = 1;
      4'h5: begin kind = 1; bor = fin[1]; end
      4'h2, 4'hA: kind = 2;
      4'h3: begin kind = 2; x = b; y = a; end
      4'h6: begin kind = 2; bor = ~fin[1]; end
      4'h7: begin kind = 2; x = b; y = a; bor = ~fin[1]; end
      default: r = '0;
    endcase
    if (kind == 1) begin
      w  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, bor};
      r  = w[MSB:0];
      cy = w[DW];
      ov = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
    end else if (kind == 2) begin
      w  = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, bor};
      r  = w[MSB:0];
      cy = ({1'b0, x} >= ({1'b0, y} + {{DW{1'b0}}, bor}));
      ov = (x[MSB] != y[MSB]) && (r[MSB] != x[MSB]);
    end
    we = (op[3:2] != 2'b10);
    fo = fin;
    if (s) begin
      fo[3] = r[MSB];
      fo[2] = (r == '0);
      if (kind == 0) fo[1] = shc;
      else begin fo[1] = cy; fo[0] = ov; end
    end
  endtask

  task automatic run_vec(input logic [3:0] op, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic s,
                         input logic shc, input logic vld);
    logic [DW-1:0] er;
    logic          ewe;
    logic [3:0]    efl;
    string         ftag;
    @(negedge clk);
    chk(flags_o == model_fl, "R5", "flags_o", 32'(flags_o), 32'(model_fl));
    valid_i = vld; opcode_i = op; op_a_i = a; op_b_i = b;
    set_flags_i = s; shift_carry_i = shc;
    #1;
    model(op, a, b, s & vld, shc, model_fl, er, ewe, efl);
    ewe = ewe & vld;
    if (vld) chk(result_o == er, res_tag(op), "result", 32'(result_o), 32'(er));
    chk(wr_en_o == ewe, "R4", "wr_en", 32'(wr_en_o), 32'(ewe));
    if (!(s & vld))                   ftag = "R9";
    else if (op == 4'h4 || op == 4'h5 || op == 4'hB) ftag = "R6";
    else if (op == 4'h2 || op == 4'h3 || op == 4'h6 ||
             op == 4'h7 || op == 4'hA) ftag = "R7";
    else                              ftag = "R8";
    chk(flags_nxt_o == efl, ftag, "flags_nxt", 32'(flags_nxt_o), 32'(efl));
    model_fl = efl;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; opcode_i = '0; set_flags_i = 1'b0;
    op_a_i = '0; op_b_i = '0; shift_carry_i = 1'b0;
    model_fl = 4'b0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(flags_o == 4'b0000, "R10", "flags_o in reset", 32'(flags_o), 32'h0);
    chk(wr_en_o == 1'b0, "R10", "wr_en in reset", 32'(wr_en_o), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(flags_o == 4'b0000, "R10", "flags_o after release", 32'(flags_o), 32'h0);

    for (int op = 0; op < 16; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
              // seed carry (and N/Z) with a flag-setting move
              run_vec(4'hD, '0, pick((ia + ib) % 16), 1'b1, c[0], 1'b1);
              run_vec(op[3:0], pick(ia), pick(ib), s[0], ~c[0], 1'b1);
              if (ib == 3 && s == 1)
                run_vec(op[3:0], pick(ib), pick(ia), 1'b1, c[0], 1'b0);
            end
          end
        end
      end
    end

    @(negedge clk);
    chk(flags_o == model_fl, "R5", "final flags_o", 32'(flags_o), 32'(model_fl));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule